// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

This block keeps a 16-bit count driven by one external input pin, which it resynchronizes internally. It has two modes. In event mode it counts pin transitions of one chosen direction. In gated mode it counts periods of a divided-by-64 copy of the core clock, but only while the pin is held at a chosen level. A single polarity control bit selects the direction in event mode and the level in gated mode.

Two sticky flags record activity. The event flag marks an active transition in event mode, or the end of an active level in gated mode. The overflow flag marks a wrap of the count from its maximum back to zero. Each flag drives its own interrupt line through its own enable bit.

Software uses a small write-strobe and address interface. Through it, software configures the block, clears flags and loads the count. The selected register is read back combinationally.

Top module: `pulse_accum`

## Requirements
- R1: After reset the count, both flags, the control register and both interrupt outputs are zero.
- R2: With control bit 0 (gated) clear, the count rises by one for each pin transition selected by control bit 1 (polarity): 0 selects high-to-low, 1 selects low-to-high. The new value appears after the third rising clock edge, counting the edge that first samples the new pin level.
- R3: In event mode every counted transition also sets the event flag (flags register bit 0). `irq_evt` is high exactly when that flag and control bit 2 (event interrupt enable) are both set.
- R4: With the gated bit set and `timer_en` high, the count rises by one once every 64 clock cycles, on those divider ticks where the synchronized pin equals the polarity bit (0 = low is active, 1 = high is active). Otherwise the count holds.
- R5: In gated mode the event flag is set when the synchronized pin leaves the active level. Entering the active level does not set it.
- R6: An increment from 0xFFFF gives 0x0000 and sets the overflow flag (flags register bit 1). `irq_ovf` is high exactly when that flag and control bit 3 (overflow interrupt enable) are both set.
- R7: Event mode counts with `timer_en` low. Gated mode does not advance while `timer_en` is low.
- R8: Writing the flags register clears each flag whose bit is written as 1 and leaves flags written as 0 unchanged. A flag that is being set in the same cycle stays set.
- R9: A write to the count register loads the 16-bit value. A write has priority over an increment in the same cycle, and the increment is then lost.
- R10: The divide-by-64 counter is held at zero unless gated mode and `timer_en` are both on. After gated mode is entered, the first tick comes 64 cycles later.
- R11: Register addresses are 0 for control, 1 for flags, 2 for count and 3 reserved (reads as 0). The control register reads back as {enable overflow, enable event, polarity, gated} in bits 3..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_en | input | 1 | Global timer enable; gates the divider only |
| pa_pin | input | 1 | Asynchronous external input |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the selected register |
| irq_evt | output | 1 | Event interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
A pin change reaches the count and the event flag three clock edges after it is driven. The two synchronizer flops come first, and the edge compare and the update share the third edge. Register writes, flag clears and interrupt changes are visible one edge after the strobe. A gated tick lands 64 edges after the divider leaves reset.

The bench drives inputs on falling edges. It steps a behavioural model at each rising edge and compares two nanoseconds later, so all of these latencies are matched edge for edge. Spot checks of whole sequences, such as wraps, load-versus-increment collisions and divider restarts, are sampled only after these delays have elapsed.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_FLAGS = 2'd1,
    ADDR_COUNT = 2'd2,
    ADDR_SPARE = 2'd3
  } pacc_addr_e;

  typedef struct packed {
    logic ovf_ie;
    logic evt_ie;
    logic pol;
    logic gated;
  } pacc_ctrl_t;

  localparam int CTRL_W = $bits(pacc_ctrl_t);

  // Transition of the direction chosen by pol (1 = low-to-high).
  function automatic logic edge_seen(input logic cur, input logic prev, input logic pol);
    return pol ? (cur & ~prev) : (~cur & prev);
  endfunction

  // Pin is at the active level chosen by pol.
  function automatic logic level_on(input logic cur, input logic pol);
    return cur == pol;
  endfunction

  // Pin just left the active level.
  function automatic logic leaving(input logic cur, input logic prev, input logic pol);
    return level_on(prev, pol) && !level_on(cur, pol);
  endfunction

endpackage

// File: rtl/pacc_sync.sv
module pacc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic lvl_prev
);

  logic [STAGES-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg      <= '0;
      lvl_prev <= 1'b0;
    end else begin
      stg      <= {stg[STAGES-2:0], pin};
      lvl_prev <= stg[STAGES-1];
    end
  end

  assign lvl = stg[STAGES-1];

  assert_prev_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> lvl_prev == $past(lvl));

endmodule

// File: rtl/pacc_prescale.sv
module pacc_prescale #(
  parameter int DIV_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == '1);

  assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  assert_idle_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);

endmodule

// File: rtl/pacc_core.sv
module pacc_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         evt_set,
  input  logic         evt_clr,
  input  logic         ovf_clr,
  output logic [W-1:0] cnt,
  output logic         evt_flag,
  output logic         ovf_flag,
  output logic         wrap
);

  function automatic logic [W:0] bump(input logic [W-1:0] v);
    return {1'b0, v} + {{W{1'b0}}, 1'b1};
  endfunction

  logic [W:0] sum;
  assign sum  = bump(cnt);
  assign wrap = inc && !load && sum[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      evt_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (load)     cnt <= load_val;
      else if (inc) cnt <= sum[W-1:0];
      evt_flag <= evt_set | (evt_flag & ~evt_clr);
      ovf_flag <= wrap | (ovf_flag & ~ovf_clr);
    end
  end

  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(load_val));

  assert_wrap_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && cnt == '1) |=> (ovf_flag && cnt == '0));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !load) |=> $stable(cnt));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clr && !evt_set) |=> !evt_flag);

endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
  import pacc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             timer_en,
  input  logic             pa_pin,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             irq_evt,
  output logic             irq_ovf
);

  localparam int PAD_CTRL = CNT_W - CTRL_W;
  localparam int PAD_FLAG = CNT_W - 2;

  pacc_ctrl_t  ctrl_q;
  pacc_addr_e  sel;
  logic        wr_ctrl, wr_flags, wr_count;
  logic        lvl, lvl_prev, tick, run;
  logic        evt_edge, gate_hit, gate_leave;
  logic        inc, evt_set;
  logic        evt_flag, ovf_flag, wrap;
  logic [CNT_W-1:0] count;

  assign sel      = pacc_addr_e'(addr);
  assign wr_ctrl  = wr_en && (sel == ADDR_CTRL);
  assign wr_flags = wr_en && (sel == ADDR_FLAGS);
  assign wr_count = wr_en && (sel == ADDR_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= pacc_ctrl_t'(wdata[CTRL_W-1:0]);
  end

  pacc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(pa_pin), .lvl(lvl), .lvl_prev(lvl_prev)
  );

  assign run = ctrl_q.gated && timer_en;

  pacc_prescale #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  assign evt_edge   = edge_seen(lvl, lvl_prev, ctrl_q.pol);
  assign gate_hit   = tick && level_on(lvl, ctrl_q.pol);
  assign gate_leave = leaving(lvl, lvl_prev, ctrl_q.pol);
  assign inc        = ctrl_q.gated ? gate_hit   : evt_edge;
  assign evt_set    = ctrl_q.gated ? gate_leave : evt_edge;

  pacc_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .inc(inc), .load(wr_count), .load_val(wdata),
    .evt_set(evt_set),
    .evt_clr(wr_flags && wdata[0]),
    .ovf_clr(wr_flags && wdata[1]),
    .cnt(count), .evt_flag(evt_flag), .ovf_flag(ovf_flag), .wrap(wrap)
  );

  always_comb begin
    case (sel)
      ADDR_CTRL:  rdata = {{PAD_CTRL{1'b0}}, ctrl_q};
      ADDR_FLAGS: rdata = {{PAD_FLAG{1'b0}}, ovf_flag, evt_flag};
      ADDR_COUNT: rdata = count;
      default:    rdata = '0;
    endcase
  end

  assign irq_evt = evt_flag && ctrl_q.evt_ie;
  assign irq_ovf = ovf_flag && ctrl_q.ovf_ie;

  assert_gated_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.gated && !timer_en && !wr_count) |=> $stable(count));

  assert_event_counts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.gated && evt_edge && !wr_count) |=> count != $past(count));

  assert_evt_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.evt_ie |-> !irq_evt);

  assert_wrap_raises_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && ctrl_q.ovf_ie && !wr_ctrl) |=> irq_ovf);

  assert_gated_edge_only_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.gated && !tick && !wr_count) |=> $stable(count));

endmodule

// File: tb/pulse_accum_test.sv
module pulse_accum_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        timer_en = 1'b0;
  logic        pa_pin = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd2;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq_evt, irq_ovf;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  pulse_accum uut (
    .clk(clk), .rst_n(rst_n), .timer_en(timer_en), .pa_pin(pa_pin),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_evt(irq_evt), .irq_ovf(irq_ovf)
  );

  // behavioural reference
  bit h[$];
  int m_cnt, m_pre;
  bit m_evf, m_ovf, m_gated, m_pol, m_evie, m_ovie;

  task automatic model_step();
    bit cur, prv, up, fset, wr;
    if (!rst_n) begin
      h = '{0, 0, 0};
      m_cnt = 0; m_pre = 0;
      m_evf = 0; m_ovf = 0; m_gated = 0; m_pol = 0; m_evie = 0; m_ovie = 0;
      return;
    end
    cur = h[1]; prv = h[2];
    if (!m_gated) begin
      up   = m_pol ? (cur && !prv) : (!cur && prv);
      fset = up;
    end else begin
      up   = timer_en && (m_pre == 63) && (cur == m_pol);
      fset = (prv == m_pol) && (cur != m_pol);
    end
    wr = 0;
    if (wr_en && addr == 2'd2) m_cnt = int'(wdata);
    else if (up) begin
      if (m_cnt == 65535) begin m_cnt = 0; wr = 1; end
      else m_cnt = m_cnt + 1;
    end
    m_evf = fset || (m_evf && !(wr_en && addr == 2'd1 && wdata[0]));
    m_ovf = wr   || (m_ovf && !(wr_en && addr == 2'd1 && wdata[1]));
    m_pre = (m_gated && timer_en) ? (m_pre + 1) % 64 : 0;
    if (wr_en && addr == 2'd0) {m_ovie, m_evie, m_pol, m_gated} = wdata[3:0];
    h.push_front(pa_pin);
    void'(h.pop_back());
  endtask

  function automatic int exp_rdata(input logic [1:0] a);
    case (a)
      2'd0: return {m_ovie, m_evie, m_pol, m_gated};
      2'd1: return {m_ovf, m_evf};
      2'd2: return m_cnt;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0h expected=%0h at %0t", req, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    model_step();
    #2;
    chk({cur_req, " rdata"}, int'(rdata), exp_rdata(addr));
    chk({cur_req, " irq_evt R3"}, int'(irq_evt), int'(m_evf && m_evie));
    chk({cur_req, " irq_ovf R6"}, int'(irq_ovf), int'(m_ovf && m_ovie));
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pin(input bit v);
    @(negedge clk); pa_pin = v;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; addr = 2'd2;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk); addr = a; #1 v = int'(rdata); addr = 2'd2;
  endtask

  task automatic pulse();
    set_pin(1'b1); idle(3); set_pin(1'b0); idle(3);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v, c1;
    idle(4);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    rd(2'd1, v); chk("R1 flags", v, 0);
    rd(2'd2, v); chk("R1 count", v, 0);
    chk("R1 irq", int'(irq_evt | irq_ovf), 0);

    // R2 R7 R3: falling edges with timer disabled
    cur_req = "R2";
    wr(2'd0, 16'h0004);
    repeat (3) pulse();
    idle(4);
    rd(2'd2, v); chk("R2 R7 falling count", v, 3);
    rd(2'd1, v); chk("R3 event flag", v & 1, 1);
    chk("R3 irq_evt", int'(irq_evt), 1);

    // R8 write-one-to-clear
    cur_req = "R8";
    wr(2'd1, 16'h0000);
    rd(2'd1, v); chk("R8 zero write keeps flag", v & 1, 1);
    wr(2'd1, 16'h0001);
    rd(2'd1, v); chk("R8 one write clears flag", v & 1, 0);
    chk("R8 irq_evt low", int'(irq_evt), 0);

    // R2 rising edges, R11 readback
    cur_req = "R2";
    wr(2'd0, 16'h0006);
    rd(2'd0, v); chk("R11 ctrl readback", v, 6);
    rd(2'd3, v); chk("R11 reserved reads zero", v, 0);
    repeat (2) pulse();
    idle(4);
    rd(2'd2, v); chk("R2 rising count", v, 5);

    // R6 wrap
    cur_req = "R6";
    wr(2'd0, 16'h000E);
    wr(2'd2, 16'hFFFE);
    repeat (2) pulse();
    idle(4);
    rd(2'd2, v); chk("R6 wrapped count", v, 0);
    rd(2'd1, v); chk("R6 overflow flag", (v >> 1) & 1, 1);
    chk("R6 irq_ovf", int'(irq_ovf), 1);
    wr(2'd1, 16'h0003);
    chk("R8 irq_ovf cleared", int'(irq_ovf), 0);

    // R9 load collides with increment
    cur_req = "R9";
    set_pin(1'b1);
    @(negedge clk);
    wr(2'd2, 16'h1234);
    idle(4);
    rd(2'd2, v); chk("R9 load beats increment", v, 'h1234);
    set_pin(1'b0); idle(5);
    rd(2'd2, v); chk("R2 falling ignored when rising selected", v, 'h1234);

    // R4 R5 gated, high level active
    cur_req = "R4";
    @(negedge clk); timer_en = 1'b1;
    wr(2'd2, 16'h0000);
    wr(2'd1, 16'h0003);
    wr(2'd0, 16'h0007);
    set_pin(1'b1); idle(5);
    rd(2'd1, v); chk("R5 entering level leaves flag clear", v & 1, 0);
    idle(64 * 5 - 5);
    rd(2'd2, v);
    checks++;
    if (v < 4 || v > 5) begin
      errors++;
      $display("FAIL R4 gated count got=%0d expected=4..5", v);
    end
    cur_req = "R5";
    set_pin(1'b0); idle(5);
    rd(2'd1, v); chk("R5 trailing sets flag", v & 1, 1);
    rd(2'd2, c1);
    idle(200);
    rd(2'd2, v); chk("R4 inactive level holds", v, c1);

    // R4 low level active
    cur_req = "R4";
    wr(2'd0, 16'h0005);
    idle(200);
    rd(2'd2, v);
    checks++;
    if (v - c1 < 3 || v - c1 > 4) begin
      errors++;
      $display("FAIL R4 low-level gated got=%0d expected=%0d..%0d", v, c1 + 3, c1 + 4);
    end

    // R7 gated frozen with timer disabled
    cur_req = "R7";
    @(negedge clk); timer_en = 1'b0;
    rd(2'd2, c1);
    idle(200);
    rd(2'd2, v); chk("R7 gated stalls without enable", v, c1);

    // R10 divider restarts on entering gated mode
    cur_req = "R10";
    @(negedge clk); timer_en = 1'b1;
    wr(2'd0, 16'h0004);
    idle(10);
    wr(2'd0, 16'h0005);
    wr(2'd2, 16'h0000);
    idle(55);
    rd(2'd2, v); chk("R10 no tick before 64 cycles", v, 0);
    idle(15);
    rd(2'd2, v); chk("R10 first tick after 64 cycles", v, 1);

    idle(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule